// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block is a byte-addressed cache placed between a processor port and a slower backing memory. Every address is split into a tag, a line index and a block offset. The index selects exactly one line. A hit requires that line to be valid and to hold the same tag as the address. Loads return the byte picked by the offset. Stores go only to the cache and mark the line dirty.

On a miss the processor port holds `cpu_ready` low while the block runs its miss sequence. If the victim line is valid and dirty, its whole block is first written to memory at the address rebuilt from the old tag and the index. The requested block is then read into the line. The request that missed is then replayed against the refilled line. For a store, that replay merges the byte and marks the line dirty. For a load, the line stays clean.

The memory side moves one whole block per transfer, addressed by block number. The sizes of the address, the capacity and the block are parameters. Two counters report the hits and misses seen since reset.

Top module: `dmc_cache`

## Requirements
- R1: The widths are derived from the parameters. Offset bits are log2 of the block size, lines are capacity divided by block size, index bits are log2 of the line count, and tag bits are whatever remains. For a 32-bit address, 32768-byte capacity and 128-byte blocks this gives 7, 256, 8 and 17. With the defaults (8-bit address, 16 bytes, 4-byte blocks) the address is {tag[3:0], index[1:0], offset[1:0]}.
- R2: Reset clears every valid and dirty bit and both counters, and leaves `mem_req` low. The first access to any line after reset therefore misses.
- R3: A load that hits raises `cpu_ready` in the cycle the request is presented, returns the byte at the offset on `cpu_rdata`, and makes no memory request.
- R4: A store that hits writes its byte only into the cache, with no memory write, and sets the line's dirty bit.
- R5: On a miss, `cpu_ready` stays low until write-back and refill have both finished. While it waits for `mem_ack`, `mem_req`, `mem_we` and `mem_addr` stay steady.
- R6: A miss whose victim is valid and dirty first writes the victim's whole block (`mem_we` high) to block address {old tag, index}, and only then reads the new block.
- R7: A miss whose victim is clean or invalid performs no memory write.
- R8: A store miss refills the line, then writes the store byte into it and leaves it dirty. A later load returns the stored byte, and a later eviction writes it back.
- R9: A load miss leaves the refilled line clean, so evicting it causes no write.
- R10: Two blocks with the same index and different tags cannot both be resident, so alternating between them misses on every access.
- R11: `hit_count` increments once per request that hits on first lookup, and `miss_count` once per request that misses. The replay after a refill counts as neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until completed |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_rdata | output | 8 | Load byte, valid with cpu_ready |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | ADDR_W-OFF_W | Block address |
| mem_wdata | output | 8*BLOCK_BYTES | Victim block for write-back |
| mem_rdata | input | 8*BLOCK_BYTES | Refill block, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the transfer |
| hit_count | output | CNT_W | Hits since reset |
| miss_count | output | CNT_W | Misses since reset |

## Verification
The hardest case to reach is a miss on a dirty line. Getting there takes a store to a line, then a later access with the same index but a different tag, so that a write-back must precede the refill. The stimulus table builds this twice. The first time, the victim was dirtied by a store hit. The second time, it was dirtied by a store that had itself missed. After each access the bench compares the bench memory model's write count and the written bytes against a reference memory. A final reset and re-access confirms that the valid bits were cleared.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   function automatic int off_bits(input int blk_bytes);
      return $clog2(blk_bytes);
   endfunction

   function automatic int line_count(input int cap_bytes, input int blk_bytes);
      return cap_bytes / blk_bytes;
   endfunction

   function automatic int idx_bits(input int cap_bytes, input int blk_bytes);
      return $clog2(cap_bytes / blk_bytes);
   endfunction

   function automatic int tag_bits(input int addr_w, input int cap_bytes, input int blk_bytes);
      return addr_w - $clog2(blk_bytes) - $clog2(cap_bytes / blk_bytes);
   endfunction

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2
   } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int LINES = 4,
   parameter int TAG_W = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             dirty_set,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic [TAG_W-1:0] rd_tag
);
   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic sel;
      assign sel = (idx == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            dirty_q[g] <= 1'b0;
            tag_q[g]   <= '0;
         end else if (sel && fill_en) begin
            valid_q[g] <= 1'b1;
            dirty_q[g] <= 1'b0;
            tag_q[g]   <= fill_tag;
         end else if (sel && dirty_set) begin
            dirty_q[g] <= 1'b1;
         end
      end
   end

   assign rd_valid = valid_q[idx];
   assign rd_dirty = dirty_q[idx];
   assign rd_tag   = tag_q[idx];

   // R4
   dirty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_set |-> rd_valid)
      else $error("dirty set on an invalid line");

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int LINES       = 4,
   parameter int BLOCK_BYTES = 4,
   parameter int IDX_W       = 2,
   parameter int OFF_W       = 2,
   localparam int BLK_W      = 8 * BLOCK_BYTES
) (
   input  logic             clk,
   input  logic [IDX_W-1:0] idx,
   input  logic [OFF_W-1:0] byte_off,
   input  logic             fill_en,
   input  logic [BLK_W-1:0] fill_data,
   input  logic             byte_we,
   input  logic [7:0]       byte_data,
   output logic [BLK_W-1:0] line_data,
   output logic [7:0]       rd_byte
);
   logic [BLK_W-1:0] mem_q [LINES];

   for (genvar b = 0; b < BLOCK_BYTES; b++) begin : g_lane
      logic lane_hit;
      assign lane_hit = byte_we && (byte_off == OFF_W'(b));
      always_ff @(posedge clk) begin
         if (fill_en)
            mem_q[idx][8*b +: 8] <= fill_data[8*b +: 8];
         else if (lane_hit)
            mem_q[idx][8*b +: 8] <= byte_data;
      end
   end

   assign line_data = mem_q[idx];
   assign rd_byte   = line_data[{byte_off, 3'b000} +: 8];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
   import dmc_pkg::*;
#(
   parameter int TAG_W = 4,
   parameter int IDX_W = 2,
   parameter int CNT_W = 16,
   localparam int BADDR_W = TAG_W + IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [TAG_W-1:0]   req_tag,
   input  logic [IDX_W-1:0]   req_idx,
   input  logic               line_valid,
   input  logic               line_dirty,
   input  logic [TAG_W-1:0]   line_tag,
   input  logic               mem_ack,
   output logic               cpu_ready,
   output logic               mem_req,
   output logic               mem_we,
   output logic [BADDR_W-1:0] mem_baddr,
   output logic               fill_en,
   output logic               dirty_set,
   output logic               byte_we,
   output logic [CNT_W-1:0]   hit_cnt,
   output logic [CNT_W-1:0]   miss_cnt
);
   dmc_state_e state_q, state_d;
   logic       replay_q;
   logic       hit;
   logic       miss_start;

   assign hit        = line_valid && (line_tag == req_tag);
   assign cpu_ready  = (state_q == ST_IDLE) && cpu_req && hit;
   assign miss_start = (state_q == ST_IDLE) && cpu_req && !hit;
   assign byte_we    = cpu_ready && cpu_we;
   assign dirty_set  = byte_we;
   assign fill_en    = (state_q == ST_FILL) && mem_ack;
   assign mem_req    = (state_q != ST_IDLE);
   assign mem_we     = (state_q == ST_WBACK);
   assign mem_baddr  = mem_we ? {line_tag, req_idx} : {req_tag, req_idx};

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (miss_start) state_d = (line_valid && line_dirty) ? ST_WBACK : ST_FILL;
         ST_WBACK: if (mem_ack) state_d = ST_FILL;
         ST_FILL:  if (mem_ack) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         replay_q <= 1'b0;
         hit_cnt  <= '0;
         miss_cnt <= '0;
      end else begin
         state_q <= state_d;
         if (fill_en)        replay_q <= 1'b1;
         else if (cpu_ready) replay_q <= 1'b0;
         if (cpu_ready && !replay_q) hit_cnt  <= hit_cnt + 1'b1;
         if (miss_start)             miss_cnt <= miss_cnt + 1'b1;
      end
   end

   // R5
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_baddr) && $stable(mem_we)))
      else $error("memory request changed before ack");

   // R6
   wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we))
      else $error("write-back not followed by refill");

   // R3
   hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ready) |-> !mem_req)
      else $error("hit completed during memory transfer");

   // R11
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones({hit_cnt != $past(hit_cnt), miss_cnt != $past(miss_cnt)}) <= 1))
      else $error("both counters stepped together");

   // R11
   cnt_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_cnt != $past(hit_cnt)) |-> (hit_cnt == $past(hit_cnt) + 1'b1))
      else $error("hit counter jumped");

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
   import dmc_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int CAPACITY    = 16,
   parameter int BLOCK_BYTES = 4,
   parameter int CNT_W       = 16,
   localparam int OFF_W      = off_bits(BLOCK_BYTES),
   localparam int LINES      = line_count(CAPACITY, BLOCK_BYTES),
   localparam int IDX_W      = idx_bits(CAPACITY, BLOCK_BYTES),
   localparam int TAG_W      = tag_bits(ADDR_W, CAPACITY, BLOCK_BYTES),
   localparam int BADDR_W    = ADDR_W - OFF_W,
   localparam int BLK_W      = 8 * BLOCK_BYTES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [7:0]         cpu_wdata,
   output logic               cpu_ready,
   output logic [7:0]         cpu_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [BADDR_W-1:0] mem_addr,
   output logic [BLK_W-1:0]   mem_wdata,
   input  logic [BLK_W-1:0]   mem_rdata,
   input  logic               mem_ack,
   output logic [CNT_W-1:0]   hit_count,
   output logic [CNT_W-1:0]   miss_count
);
   initial begin
      blk_pow2_chk: assert (BLOCK_BYTES >= 2 && (BLOCK_BYTES & (BLOCK_BYTES - 1)) == 0)
         else $error("block size must be a power of two, at least 2");
      lines_pow2_chk: assert (LINES >= 2 && (LINES & (LINES - 1)) == 0)
         else $error("line count must be a power of two, at least 2");
      tag_width_chk: assert (TAG_W >= 1)
         else $error("address too narrow for capacity");
   end

   logic [OFF_W-1:0] req_off;
   logic [IDX_W-1:0] req_idx;
   logic [TAG_W-1:0] req_tag;
   assign {req_tag, req_idx, req_off} = cpu_addr;

   logic             line_valid, line_dirty;
   logic [TAG_W-1:0] line_tag;
   logic             fill_en, dirty_set, byte_we;

   dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (req_idx),
      .fill_en  (fill_en),
      .fill_tag (req_tag),
      .dirty_set(dirty_set),
      .rd_valid (line_valid),
      .rd_dirty (line_dirty),
      .rd_tag   (line_tag)
   );

   dmc_data_store #(.LINES(LINES), .BLOCK_BYTES(BLOCK_BYTES), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
      .clk      (clk),
      .idx      (req_idx),
      .byte_off (req_off),
      .fill_en  (fill_en),
      .fill_data(mem_rdata),
      .byte_we  (byte_we),
      .byte_data(cpu_wdata),
      .line_data(mem_wdata),
      .rd_byte  (cpu_rdata)
   );

   dmc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .req_tag   (req_tag),
      .req_idx   (req_idx),
      .line_valid(line_valid),
      .line_dirty(line_dirty),
      .line_tag  (line_tag),
      .mem_ack   (mem_ack),
      .cpu_ready (cpu_ready),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_baddr (mem_addr),
      .fill_en   (fill_en),
      .dirty_set (dirty_set),
      .byte_we   (byte_we),
      .hit_cnt   (hit_count),
      .miss_cnt  (miss_count)
   );

endmodule

// File: tb/sim_dmc_cache.sv
module sim_dmc_cache;
   import dmc_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;
   localparam int NVEC       = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [7:0]  cpu_addr = '0, cpu_wdata = '0;
   logic        cpu_ready;
   logic [7:0]  cpu_rdata;
   logic        mem_req, mem_we;
   logic [5:0]  mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic        mem_ack;
   logic [15:0] hit_count, miss_count;

   int checks = 0, errors = 0;
   int wr_cnt;
   int lat_cnt;
   logic [7:0] bmem    [256];
   logic [7:0] ref_mem [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   dmc_cache u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count)
   );

   // backing memory: whole-block transfers, fixed latency, one-cycle ack
   always_comb
      for (int b = 0; b < 4; b++) mem_rdata[8*b +: 8] = bmem[{mem_addr, 2'(b)}];

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         lat_cnt <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
         if (mem_we) begin
            for (int b = 0; b < 4; b++) bmem[{mem_addr, 2'(b)}] = mem_wdata[8*b +: 8];
            wr_cnt = wr_cnt + 1;
         end
      end else if (mem_req) begin
         if (lat_cnt == LAT - 1) begin
            mem_ack <= 1'b1;
            lat_cnt <= 0;
         end else lat_cnt <= lat_cnt + 1;
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [7:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output int stall);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      stall = 0;
      #1;
      while (!cpu_ready && stall < 60) begin
         stall++;
         @(negedge clk);
      end
      rd = cpu_rdata;
      @(posedge clk);
      #1 cpu_req = 1'b0;
   endtask

   // {we, addr, wdata, expect_hit, expected memory writes so far}
   localparam logic [21:0] VEC [NVEC] = '{
      {1'b0, 8'h00, 8'h00, 1'b0, 4'd0},  // R2 first touch misses
      {1'b0, 8'h01, 8'h00, 1'b1, 4'd0},  // R3 load hit
      {1'b1, 8'h02, 8'hAA, 1'b1, 4'd0},  // R4 store hit, no write
      {1'b0, 8'h02, 8'h00, 1'b1, 4'd0},  // R4 reads stored byte
      {1'b0, 8'h40, 8'h00, 1'b0, 4'd1},  // R6 dirty victim written back
      {1'b0, 8'h02, 8'h00, 1'b0, 4'd1},  // R7 clean victim
      {1'b1, 8'h45, 8'h55, 1'b0, 4'd1},  // R8 store miss
      {1'b0, 8'h45, 8'h00, 1'b1, 4'd1},  // R8 merged byte
      {1'b0, 8'h44, 8'h00, 1'b1, 4'd1},  // R8 rest of block
      {1'b0, 8'h80, 8'h00, 1'b0, 4'd1},  // R10 conflict
      {1'b0, 8'h00, 8'h00, 1'b0, 4'd1},  // R10
      {1'b0, 8'h80, 8'h00, 1'b0, 4'd1},  // R10
      {1'b0, 8'h00, 8'h00, 1'b0, 4'd1},  // R10
      {1'b1, 8'hC4, 8'h77, 1'b0, 4'd2},  // R8 store-missed line written back
      {1'b0, 8'h45, 8'h00, 1'b0, 4'd3},  // R6
      {1'b0, 8'hC4, 8'h00, 1'b0, 4'd3},  // R9 load-miss line clean
      {1'b1, 8'hFF, 8'h11, 1'b0, 4'd3},  // R7 invalid victim
      {1'b0, 8'hFC, 8'h00, 1'b1, 4'd3}   // R3
   };

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      int stall;
      wr_cnt = 0;
      for (int i = 0; i < 256; i++) begin
         bmem[i] = 8'(i * 7 + 3);
         ref_mem[i] = bmem[i];
      end

      // R1 width derivation
      check("R1 offset bits", off_bits(128), 7);
      check("R1 lines", line_count(32768, 128), 256);
      check("R1 index bits", idx_bits(32768, 128), 8);
      check("R1 tag bits", tag_bits(32, 32768, 128), 17);
      check("R1 default tag bits", tag_bits(8, 16, 4), 4);

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R2 reset state
      check("R2 hit_count", hit_count, 0);
      check("R2 miss_count", miss_count, 0);
      check("R2 mem_req", mem_req, 0);
      check("R2 cpu_ready", cpu_ready, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         logic        we;
         logic [7:0]  a, d;
         logic        eh;
         logic [3:0]  ew;
         {we, a, d, eh, ew} = VEC[i];
         access(we, a, d, rd, stall);
         check($sformatf("R5 R10 hit/miss vec%0d", i), (stall == 0), eh);
         if (we) ref_mem[a] = d;
         else check($sformatf("R3 R8 load data vec%0d", i), rd, ref_mem[a]);
         check($sformatf("R6 R7 R9 mem writes vec%0d", i), wr_cnt, ew);
         if (i == 4)  check("R6 written-back byte", bmem[8'h02], 8'hAA);
         if (i == 13) check("R8 written-back store byte", bmem[8'h45], 8'h55);
         if (i == 14) check("R6 second write-back byte", bmem[8'hC4], 8'h77);
      end

      check("R11 hit_count", hit_count, 6);
      check("R11 miss_count", miss_count, 12);

      // R2 reset invalidates resident lines
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R2 counters cleared", {hit_count, miss_count}, 0);
      access(1'b0, 8'hFC, 8'h00, rd, stall);
      check("R2 miss after reset", (stall != 0), 1);
      check("R2 miss counted", miss_count, 1);
      check("R3 data after reset", rd, ref_mem[8'hFC]);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule